// File: doc/BRIEF.md
# Warp Spawn and Thread Control

This block tracks, for every warp of a small multi-warp core, whether the warp has been started, its program counter, how many of its hardware lanes are active, and whether it runs in user or supervisor mode. It executes the thread-control commands that an issue stage hands it. The commands cover starting a new warp, jumping while dropping to a single thread, jumping with a link and a new thread count, halting through an environment call, and dropping the issuing warp to user mode.

Each command arrives as a one-cycle strobe with an opcode, the issuing warp id, two source operand values and the current PC. The issue stage acts on the registered results. These are a PC redirect, a link value, an interrupt with its cause, an error pulse for an impossible thread count, a pulse when no warp is free, and a copy request. The copy request names the newly started warp, and the register-file logic uses it to duplicate the spawner's registers and CSRs.

Top module: `warp_ctrl`

## Requirements
- R1: After reset, warp 0 is started in supervisor mode at BOOT_PC with one active thread. Every other warp is unstarted, with a PC of 0 and no active threads. All pulse outputs are low.
- R2: A spawn command (opcode 1) starts the lowest-numbered unstarted warp. That warp gets PC = src_a, one active thread and user mode. Its started flag stays set from then on.
- R3: A spawn that starts a warp raises copy_req for exactly one cycle, with copy_warp holding the id of the started warp.
- R4: A spawn when every warp is already started changes no warp state and does not raise copy_req. It pulses no_free_warp for one cycle.
- R5: A single-thread jump (opcode 2) sets the issuing warp's active count to 1 and its PC to src_a. It also pulses redirect_valid with redirect_pc = src_a.
- R6: A counted jump-and-link (opcode 3) with src_b no greater than NUM_LANES sets the active count to src_b and the PC to src_a. It redirects to src_a and pulses link_valid with link_value = cmd_pc.
- R7: A counted jump-and-link with src_b greater than NUM_LANES pulses thread_err and leaves the warp state unchanged. It raises no redirect and no link.
- R8: An environment call (opcode 4) sets the issuing warp's active count to 0. It pulses irq_valid with irq_cause 0.
- R9: Drop-privilege (opcode 5) is privileged. From a supervisor warp it switches that warp to user mode. From a user warp it changes nothing and pulses irq_valid with irq_cause 3.
- R10: A command from an unstarted warp has no effect and raises no output pulse. Opcodes 0, 6 and 7 also have no effect and raise no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_warp | input | WID | Issuing warp id |
| cmd_pc | input | XLEN | PC of the issuing command |
| src_a | input | XLEN | First source operand (target PC) |
| src_b | input | XLEN | Second source operand (thread count) |
| warp_spawned | output | NUM_WARPS | Started flag per warp |
| warp_user | output | NUM_WARPS | User-mode flag per warp |
| warp_threads | output | NUM_WARPS*CW | Active thread count per warp, warp i at bits [i*CW +: CW] |
| warp_pc | output | NUM_WARPS*XLEN | PC per warp, warp i at bits [i*XLEN +: XLEN] |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| link_valid | output | 1 | Link value pulse |
| link_value | output | XLEN | Return PC to write back |
| copy_req | output | 1 | Register/CSR copy request pulse |
| copy_warp | output | WID | Warp receiving the copy |
| irq_valid | output | 1 | Interrupt pulse |
| irq_cause | output | 4 | Interrupt cause |
| no_free_warp | output | 1 | Spawn found no free warp |
| thread_err | output | 1 | Requested thread count exceeds lanes |

## Verification
Every result is registered once. The warp table and all pulses reflect a command at the first rising edge that samples its strobe, and each pulse falls one cycle later unless another command follows. The bench drives a command on a falling edge and drops the strobe at the next falling edge. It then reads every output at once, which places each sample half a cycle after the edge that produced it. The copy-request test waits one cycle more to confirm that the pulse has ended.

// File: rtl/warp_ctrl.sv
module warp_ctrl #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_LANES = 4,
  parameter int XLEN      = 32,
  parameter logic [XLEN-1:0] BOOT_PC = XLEN'('h100),
  localparam int WID = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CW  = $clog2(NUM_LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [WID-1:0]            cmd_warp,
  input  logic [XLEN-1:0]           cmd_pc,
  input  logic [XLEN-1:0]           src_a,
  input  logic [XLEN-1:0]           src_b,
  output logic [NUM_WARPS-1:0]      warp_spawned,
  output logic [NUM_WARPS-1:0]      warp_user,
  output logic [NUM_WARPS*CW-1:0]   warp_threads,
  output logic [NUM_WARPS*XLEN-1:0] warp_pc,
  output logic                      redirect_valid,
  output logic [XLEN-1:0]           redirect_pc,
  output logic                      link_valid,
  output logic [XLEN-1:0]           link_value,
  output logic                      copy_req,
  output logic [WID-1:0]            copy_warp,
  output logic                      irq_valid,
  output logic [3:0]                irq_cause,
  output logic                      no_free_warp,
  output logic                      thread_err
);

  localparam logic [2:0] OP_SPAWN = 3'd1;
  localparam logic [2:0] OP_JONE  = 3'd2;
  localparam logic [2:0] OP_JLCNT = 3'd3;
  localparam logic [2:0] OP_ECALL = 3'd4;
  localparam logic [2:0] OP_DROP  = 3'd5;

  logic [XLEN-1:0] pc_q  [NUM_WARPS];
  logic [CW-1:0]   thr_q [NUM_WARPS];
  logic [NUM_WARPS-1:0] spawned_q, user_q;

  logic           free_found;
  logic [WID-1:0] free_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (!spawned_q[i]) begin
        free_found = 1'b1;
        free_idx   = WID'(i);
      end
    end
  end

  wire live   = cmd_valid && spawned_q[cmd_warp];
  wire is_usr = user_q[cmd_warp];
  wire cnt_ok = src_b <= XLEN'(NUM_LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WARPS; i++) begin
        pc_q[i]  <= (i == 0) ? BOOT_PC : '0;
        thr_q[i] <= (i == 0) ? CW'(1) : '0;
      end
      spawned_q      <= NUM_WARPS'(1);
      user_q         <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      link_valid     <= 1'b0;
      link_value     <= '0;
      copy_req       <= 1'b0;
      copy_warp      <= '0;
      irq_valid      <= 1'b0;
      irq_cause      <= '0;
      no_free_warp   <= 1'b0;
      thread_err     <= 1'b0;
    end else begin
      redirect_valid <= 1'b0;
      link_valid     <= 1'b0;
      copy_req       <= 1'b0;
      irq_valid      <= 1'b0;
      no_free_warp   <= 1'b0;
      thread_err     <= 1'b0;
      if (live) begin
        case (cmd_op)
          OP_SPAWN: begin
            if (free_found) begin
              spawned_q[free_idx] <= 1'b1;
              user_q[free_idx]    <= 1'b1;
              pc_q[free_idx]      <= src_a;
              thr_q[free_idx]     <= CW'(1);
              copy_req            <= 1'b1;
              copy_warp           <= free_idx;
            end else begin
              no_free_warp <= 1'b1;
            end
          end
          OP_JONE: begin
            thr_q[cmd_warp] <= CW'(1);
            pc_q[cmd_warp]  <= src_a;
            redirect_valid  <= 1'b1;
            redirect_pc     <= src_a;
          end
          OP_JLCNT: begin
            if (cnt_ok) begin
              thr_q[cmd_warp] <= src_b[CW-1:0];
              pc_q[cmd_warp]  <= src_a;
              redirect_valid  <= 1'b1;
              redirect_pc     <= src_a;
              link_valid      <= 1'b1;
              link_value      <= cmd_pc;
            end else begin
              thread_err <= 1'b1;
            end
          end
          OP_ECALL: begin
            thr_q[cmd_warp] <= '0;
            irq_valid       <= 1'b1;
            irq_cause       <= 4'd0;
          end
          OP_DROP: begin
            if (is_usr) begin
              irq_valid <= 1'b1;
              irq_cause <= 4'd3;
            end else begin
              user_q[cmd_warp] <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign warp_spawned = spawned_q;
  assign warp_user    = user_q;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_flat
    assign warp_threads[g*CW +: CW]     = thr_q[g];
    assign warp_pc[g*XLEN +: XLEN]      = pc_q[g];
  end

endmodule

// File: rtl/warp_ctrl_chk.sv
module warp_ctrl_chk #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_LANES = 4,
  parameter int XLEN      = 32,
  localparam int WID = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CW  = $clog2(NUM_LANES + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_WARPS-1:0]      warp_spawned,
  input logic [NUM_WARPS-1:0]      warp_user,
  input logic [NUM_WARPS*CW-1:0]   warp_threads,
  input logic                      redirect_valid,
  input logic                      link_valid,
  input logic                      copy_req,
  input logic [WID-1:0]            copy_warp,
  input logic                      irq_valid,
  input logic [3:0]                irq_cause,
  input logic                      no_free_warp,
  input logic                      thread_err
);

  p_spawn_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(warp_spawned) & ~warp_spawned) == '0));

  p_copy_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> (warp_spawned[copy_warp] && warp_user[copy_warp]));

  p_copy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |=> !copy_req || (warp_spawned != $past(warp_spawned)));

  p_nofree_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    no_free_warp |-> ((&warp_spawned) && !copy_req));

  p_link_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> redirect_valid);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thread_err |-> (!redirect_valid && !link_valid));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_cause == 4'd0 || irq_cause == 4'd3));

  p_user_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(warp_user) & ~warp_user) == '0));

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_lane
    p_lane_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      warp_threads[g*CW +: CW] <= CW'(NUM_LANES));
  end

endmodule

bind warp_ctrl warp_ctrl_chk #(
  .NUM_WARPS(NUM_WARPS),
  .NUM_LANES(NUM_LANES),
  .XLEN(XLEN)
) u_chk (.*);

// File: tb/warp_ctrl_tb.sv
module warp_ctrl_tb;
  localparam int NW = 4, NL = 4, XL = 32, WID = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [WID-1:0] cmd_warp = '0;
  logic [XL-1:0] cmd_pc = '0, src_a = '0, src_b = '0;
  logic [NW-1:0] warp_spawned, warp_user;
  logic [NW*CW-1:0] warp_threads;
  logic [NW*XL-1:0] warp_pc;
  logic redirect_valid, link_valid, copy_req, irq_valid, no_free_warp, thread_err;
  logic [XL-1:0] redirect_pc, link_value;
  logic [WID-1:0] copy_warp;
  logic [3:0] irq_cause;

  int checks = 0, errors = 0;

  warp_ctrl #(.NUM_WARPS(NW), .NUM_LANES(NL), .XLEN(XL), .BOOT_PC(32'h100)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] thr(input int w);
    return 32'(warp_threads[w*CW +: CW]);
  endfunction

  function automatic logic [31:0] wpc(input int w);
    return warp_pc[w*XL +: XL];
  endfunction

  task automatic issue(input logic [2:0] op, input int w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] pc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_warp = WID'(w);
    src_a = a; src_b = b; cmd_pc = pc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [31:0] pulses();
    return {26'd0, redirect_valid, link_valid, copy_req, irq_valid, no_free_warp, thread_err};
  endfunction

  task automatic t_reset;
    chk("R1 spawned", 32'(warp_spawned), 32'h1);
    chk("R1 user", 32'(warp_user), 32'h0);
    chk("R1 w0 pc", wpc(0), 32'h100);
    chk("R1 w0 threads", thr(0), 1);
    chk("R1 w3 threads", thr(3), 0);
    chk("R1 pulses", pulses(), 0);
  endtask

  task automatic t_unspawned;
    issue(3'd2, 2, 32'h500, 0, 0);
    chk("R10 unspawned pulses", pulses(), 0);
    chk("R10 unspawned threads", thr(2), 0);
    chk("R10 unspawned pc", wpc(2), 0);
    issue(3'd6, 0, 32'h500, 0, 0);
    chk("R10 reserved op pulses", pulses(), 0);
    chk("R10 reserved op pc", wpc(0), 32'h100);
  endtask

  task automatic t_spawn;
    issue(3'd1, 0, 32'h200, 0, 0);
    chk("R2 spawned", 32'(warp_spawned), 32'h3);
    chk("R2 pc", wpc(1), 32'h200);
    chk("R2 threads", thr(1), 1);
    chk("R2 user", 32'(warp_user), 32'h2);
    chk("R3 copy_req", 32'(copy_req), 1);
    chk("R3 copy_warp", 32'(copy_warp), 1);
    @(negedge clk);
    chk("R3 copy_req one cycle", 32'(copy_req), 0);
    issue(3'd1, 1, 32'h240, 0, 0);
    chk("R2 second slot", 32'(copy_warp), 2);
    issue(3'd1, 0, 32'h280, 0, 0);
    chk("R2 third slot", 32'(copy_warp), 3);
    chk("R2 all spawned", 32'(warp_spawned), 32'hF);
  endtask

  task automatic t_full;
    issue(3'd1, 0, 32'h2C0, 0, 0);
    chk("R4 no_free_warp", 32'(no_free_warp), 1);
    chk("R4 no copy", 32'(copy_req), 0);
    chk("R4 pc w3 kept", wpc(3), 32'h280);
    chk("R4 pc w0 kept", wpc(0), 32'h100);
  endtask

  task automatic t_jlcnt;
    issue(3'd3, 1, 32'h300, 3, 32'h210);
    chk("R6 redirect", 32'(redirect_valid), 1);
    chk("R6 target", redirect_pc, 32'h300);
    chk("R6 link", 32'(link_valid), 1);
    chk("R6 link value", link_value, 32'h210);
    chk("R6 threads", thr(1), 3);
    chk("R6 pc", wpc(1), 32'h300);
    issue(3'd3, 1, 32'h340, 5, 32'h300);
    chk("R7 thread_err", 32'(thread_err), 1);
    chk("R7 no redirect/link", 32'({redirect_valid, link_valid}), 0);
    chk("R7 threads kept", thr(1), 3);
    chk("R7 pc kept", wpc(1), 32'h300);
    issue(3'd3, 1, 32'h360, 4, 32'h300);
    chk("R6 boundary threads", thr(1), 4);
    chk("R6 boundary no err", 32'(thread_err), 0);
  endtask

  task automatic t_jone;
    issue(3'd2, 1, 32'h400, 0, 0);
    chk("R5 threads", thr(1), 1);
    chk("R5 redirect", 32'(redirect_valid), 1);
    chk("R5 target", redirect_pc, 32'h400);
    chk("R5 no link", 32'(link_valid), 0);
  endtask

  task automatic t_ecall;
    issue(3'd4, 2, 0, 0, 0);
    chk("R8 threads", thr(2), 0);
    chk("R8 irq", 32'(irq_valid), 1);
    chk("R8 cause", 32'(irq_cause), 0);
  endtask

  task automatic t_priv;
    issue(3'd5, 3, 0, 0, 0);
    chk("R9 user irq", 32'(irq_valid), 1);
    chk("R9 user cause", 32'(irq_cause), 3);
    chk("R9 user mode kept", 32'(warp_user), 32'hE);
    issue(3'd5, 0, 0, 0, 0);
    chk("R9 super no irq", 32'(irq_valid), 0);
    chk("R9 super drops", 32'(warp_user), 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unspawned();
    t_spawn();
    t_full();
    t_jlcnt();
    t_jone();
    t_ecall();
    t_priv();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule